// File: doc/BRIEF.md
# System Power Mode Controller

This block sequences the low-power states of a small microcontroller. The system runs in an active state. While the CPU and all peripherals are idle, one of two idle sub-modes applies. The first is a constant-latency sub-mode, which keeps base resources forced on so that wakeup time is fixed. The second is a low-power sub-mode, whose wakeup time varies. Software selects the sub-mode with two one-cycle task strobes.

Software enters the deepest off state with a one-cycle off request. If a peripheral is still busy, for example during a DMA transfer, the request is held pending until the busy indication clears. In the off state the core supply is removed and RAM sections are unpowered. A section keeps its contents only when its retention bit is set. Any of four level-sensitive wake sources ends the off state: pin detect, analog comparator detect, field sense or external reset. Execution never resumes after a wake. The block always issues a system reset pulse instead. While the debug interface is active, the off state is only emulated: the core and the memories stay powered.

The CPU idle input produces one-cycle sleep-enter and sleep-exit event pulses.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: An off request while `periph_busy` is low moves the block to the off state on the next clock edge. `sys_off` then reads 1 and `core_pwr_en` reads 0.
- R2: An off request while `periph_busy` is high is held pending, and `sys_off` stays 0. The off state is entered on the first clock edge at which `periph_busy` is low.
- R3: In the off state, any one of `wake_pin`, `wake_analog`, `wake_field` or `wake_reset` high for a single cycle wakes the block. With no wake input high, the block stays off, and a further off request has no effect. Outside the off state, the wake inputs have no effect.
- R4: A wake raises `sys_reset_req` for exactly `WAKE_RST_CYCLES` cycles, starting on the edge that samples the wake input. The block then returns to the active state with the sub-mode reset to low power.
- R5: If `dbg_active` is high when the off state is entered, the off state is emulated. `sys_off` reads 1, while `core_pwr_en` stays 1 and `ram_pwr` keeps following `sect_on` until the wake. The emulation choice is latched on entry.
- R6: After reset the block is active (`sys_off`=0, `core_pwr_en`=1, `sys_reset_req`=0) and the sub-mode is low power.
- R7: A `task_const_lat` strobe selects constant latency and a `task_low_pwr` strobe selects low power. If both strobes arrive in the same cycle, constant latency wins. Strobes are ignored while the block is off or waking.
- R8: `base_force_on` is 1 only when the sub-mode is constant latency, `cpu_idle` is 1, `periph_busy` is 0 and the block is not off or waking.
- R9: A rise of `cpu_idle` gives a one-cycle `ev_sleep_enter` pulse one edge later, and a fall gives a one-cycle `ev_sleep_exit` pulse one edge later. No pulses occur while the block is off or waking.
- R10: Outside a real off state, bit i of `ram_pwr` equals `sect_on[i]` and bit i of `ram_ret` equals `sect_on[i] | ret_en[i]`. In a real (non-emulated) off state, `ram_pwr` is all zero and `ram_ret` equals `ret_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| off_req | input | 1 | One-cycle off request strobe |
| task_const_lat | input | 1 | Select constant-latency sub-mode |
| task_low_pwr | input | 1 | Select low-power sub-mode |
| wake_pin | input | 1 | Digital pin detect wake level |
| wake_analog | input | 1 | Analog comparator detect wake level |
| wake_field | input | 1 | Field sense wake level |
| wake_reset | input | 1 | External reset wake level |
| dbg_active | input | 1 | Debug interface active |
| cpu_idle | input | 1 | CPU is sleeping |
| periph_busy | input | 1 | A peripheral has work in flight |
| sect_on | input | NUM_SECTIONS | Per-section power setting in the active state |
| ret_en | input | NUM_SECTIONS | Per-section retention setting |
| sys_off | output | 1 | Off state (real or emulated) |
| core_pwr_en | output | 1 | Core supply enable |
| base_force_on | output | 1 | Base resources forced on |
| sys_reset_req | output | 1 | System reset request after wake |
| ev_sleep_enter | output | 1 | Sleep-enter event pulse |
| ev_sleep_exit | output | 1 | Sleep-exit event pulse |
| ram_pwr | output | NUM_SECTIONS | Per-section RAM power |
| ram_ret | output | NUM_SECTIONS | Per-section RAM retention |

## Verification
The bench builds the block with `WAKE_RST_CYCLES` set to 3 and `NUM_SECTIONS` set to 4. The short reset window lets every cycle of the wake reset pulse, and its end, be sampled edge by edge. Four sections are driven with different power and retention bits, so one pass covers all four combinations per section. This separates the active, real-off and emulated-off RAM outputs.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;
  typedef enum logic [1:0] {
    ST_ACTIVE   = 2'd0,
    ST_OFF_WAIT = 2'd1,
    ST_OFF      = 2'd2,
    ST_WAKE     = 2'd3
  } pwr_state_e;

  typedef enum logic {
    SUB_LOWPWR   = 1'b0,
    SUB_CONSTLAT = 1'b1
  } sub_mode_e;
endpackage

// File: rtl/pwr_seq_fsm.sv
module pwr_seq_fsm
  import pwr_mode_pkg::*;
#(
  parameter int WAKE_RST_CYCLES = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       off_req,
  input  logic       periph_busy,
  input  logic       wake_any,
  input  logic       dbg_active,
  output pwr_state_e state_o,
  output logic       off_emul_o,
  output logic       rst_req_o
);
  localparam int CW = (WAKE_RST_CYCLES < 2) ? 1 : $clog2(WAKE_RST_CYCLES);
  localparam logic [CW-1:0] CNT_LOAD = CW'(WAKE_RST_CYCLES - 1);

  pwr_state_e    state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          emul_q, emul_d;
  logic          enter_off;

  always_comb begin
    state_d   = state_q;
    cnt_d     = cnt_q;
    enter_off = 1'b0;
    unique case (state_q)
      ST_ACTIVE: begin
        if (off_req && !periph_busy) begin
          state_d   = ST_OFF;
          enter_off = 1'b1;
        end else if (off_req) begin
          state_d = ST_OFF_WAIT;
        end
      end
      ST_OFF_WAIT: begin
        if (!periph_busy) begin
          state_d   = ST_OFF;
          enter_off = 1'b1;
        end
      end
      ST_OFF: begin
        if (wake_any) begin
          state_d = ST_WAKE;
          cnt_d   = CNT_LOAD;
        end
      end
      ST_WAKE: begin
        if (cnt_q == '0) state_d = ST_ACTIVE;
        else             cnt_d   = cnt_q - 1'b1;
      end
      default: state_d = ST_ACTIVE;
    endcase
    emul_d = enter_off ? dbg_active : emul_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_ACTIVE;
      cnt_q   <= '0;
      emul_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      emul_q  <= emul_d;
    end
  end

  assign state_o    = state_q;
  assign off_emul_o = emul_q;
  assign rst_req_o  = (state_q == ST_WAKE);

  AST_OFF_DIRECT: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ACTIVE && off_req && !periph_busy) |=> state_q == ST_OFF); // R1
  AST_OFF_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_OFF_WAIT && periph_busy) |=> state_q == ST_OFF_WAIT); // R2
  AST_STAY_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_OFF && !wake_any) |=> state_q == ST_OFF); // R3
  AST_WAKE_RST: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_OFF && wake_any) |=> rst_req_o); // R4
  AST_RST_END: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WAKE && cnt_q == '0) |=> state_q == ST_ACTIVE); // R4
endmodule

// File: rtl/pwr_submode.sv
module pwr_submode
  import pwr_mode_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      core_live,
  input  logic      wake_rst,
  input  logic      task_const,
  input  logic      task_low,
  input  logic      cpu_idle,
  input  logic      periph_busy,
  output sub_mode_e mode_o,
  output logic      base_force_o
);
  sub_mode_e mode_q, mode_d;

  always_comb begin
    mode_d = mode_q;
    if (wake_rst)                     mode_d = SUB_LOWPWR;
    else if (core_live && task_const) mode_d = SUB_CONSTLAT;
    else if (core_live && task_low)   mode_d = SUB_LOWPWR;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= SUB_LOWPWR;
    else        mode_q <= mode_d;
  end

  assign mode_o       = mode_q;
  assign base_force_o = core_live && (mode_q == SUB_CONSTLAT) && cpu_idle && !periph_busy;

  AST_CONST_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (core_live && task_const && !wake_rst) |=> mode_q == SUB_CONSTLAT); // R7
  AST_WAKE_LOWPWR: assert property (@(posedge clk) disable iff (!rst_n)
    wake_rst |=> mode_q == SUB_LOWPWR); // R4
endmodule

// File: rtl/pwr_sleep_evt.sv
module pwr_sleep_evt (
  input  logic clk,
  input  logic rst_n,
  input  logic core_live,
  input  logic cpu_idle,
  output logic ev_enter_o,
  output logic ev_exit_o
);
  logic idle_q;
  logic enter_q, enter_d;
  logic exit_q, exit_d;

  always_comb begin
    enter_d = core_live &&  cpu_idle && !idle_q;
    exit_d  = core_live && !cpu_idle &&  idle_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idle_q  <= 1'b0;
      enter_q <= 1'b0;
      exit_q  <= 1'b0;
    end else begin
      idle_q  <= cpu_idle;
      enter_q <= enter_d;
      exit_q  <= exit_d;
    end
  end

  assign ev_enter_o = enter_q;
  assign ev_exit_o  = exit_q;

  AST_ENTER_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    enter_q |=> !enter_q); // R9
  AST_EXIT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    exit_q |=> !exit_q); // R9
  AST_EVT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({enter_q, exit_q})); // R9
endmodule

// File: rtl/pwr_ram_ctl.sv
module pwr_ram_ctl #(
  parameter int NUM_SECTIONS = 4
) (
  input  logic                    hard_off,
  input  logic [NUM_SECTIONS-1:0] sect_on,
  input  logic [NUM_SECTIONS-1:0] ret_en,
  output logic [NUM_SECTIONS-1:0] ram_pwr,
  output logic [NUM_SECTIONS-1:0] ram_ret
);
  for (genvar g = 0; g < NUM_SECTIONS; g++) begin : g_sect
    always_comb begin
      if (hard_off) begin
        ram_pwr[g] = 1'b0;
        ram_ret[g] = ret_en[g];
      end else begin
        ram_pwr[g] = sect_on[g];
        ram_ret[g] = sect_on[g] | ret_en[g];
      end
    end
  end
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pwr_mode_pkg::*;
#(
  parameter int NUM_SECTIONS    = 4,
  parameter int WAKE_RST_CYCLES = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    off_req,
  input  logic                    task_const_lat,
  input  logic                    task_low_pwr,
  input  logic                    wake_pin,
  input  logic                    wake_analog,
  input  logic                    wake_field,
  input  logic                    wake_reset,
  input  logic                    dbg_active,
  input  logic                    cpu_idle,
  input  logic                    periph_busy,
  input  logic [NUM_SECTIONS-1:0] sect_on,
  input  logic [NUM_SECTIONS-1:0] ret_en,
  output logic                    sys_off,
  output logic                    core_pwr_en,
  output logic                    base_force_on,
  output logic                    sys_reset_req,
  output logic                    ev_sleep_enter,
  output logic                    ev_sleep_exit,
  output logic [NUM_SECTIONS-1:0] ram_pwr,
  output logic [NUM_SECTIONS-1:0] ram_ret
);
  logic       rs_meta_q, rs_n_q;
  pwr_state_e state;
  sub_mode_e  mode;
  logic       off_emul, wake_any, core_live, hard_off;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_meta_q <= 1'b0;
      rs_n_q    <= 1'b0;
    end else begin
      rs_meta_q <= 1'b1;
      rs_n_q    <= rs_meta_q;
    end
  end

  assign wake_any  = wake_pin | wake_analog | wake_field | wake_reset;
  assign core_live = (state == ST_ACTIVE) || (state == ST_OFF_WAIT);
  assign sys_off   = (state == ST_OFF);
  assign hard_off  = sys_off && !off_emul;
  assign core_pwr_en = !hard_off;

  pwr_seq_fsm #(.WAKE_RST_CYCLES(WAKE_RST_CYCLES)) u_fsm (
    .clk(clk), .rst_n(rs_n_q), .off_req(off_req), .periph_busy(periph_busy),
    .wake_any(wake_any), .dbg_active(dbg_active), .state_o(state),
    .off_emul_o(off_emul), .rst_req_o(sys_reset_req)
  );

  pwr_submode u_sub (
    .clk(clk), .rst_n(rs_n_q), .core_live(core_live), .wake_rst(sys_reset_req),
    .task_const(task_const_lat), .task_low(task_low_pwr), .cpu_idle(cpu_idle),
    .periph_busy(periph_busy), .mode_o(mode), .base_force_o(base_force_on)
  );

  pwr_sleep_evt u_evt (
    .clk(clk), .rst_n(rs_n_q), .core_live(core_live), .cpu_idle(cpu_idle),
    .ev_enter_o(ev_sleep_enter), .ev_exit_o(ev_sleep_exit)
  );

  pwr_ram_ctl #(.NUM_SECTIONS(NUM_SECTIONS)) u_ram (
    .hard_off(hard_off), .sect_on(sect_on), .ret_en(ret_en),
    .ram_pwr(ram_pwr), .ram_ret(ram_ret)
  );

  AST_EMUL_POWERED: assert property (@(posedge clk) disable iff (!rs_n_q)
    ($rose(sys_off) && $past(dbg_active)) |-> core_pwr_en); // R5
  AST_RAM_DARK: assert property (@(posedge clk) disable iff (!rs_n_q)
    (sys_off && !core_pwr_en) |-> ram_pwr == '0); // R10
  AST_BASE_NOT_OFF: assert property (@(posedge clk) disable iff (!rs_n_q)
    (sys_off || sys_reset_req) |-> !base_force_on); // R8
  AST_BASE_MODE: assert property (@(posedge clk) disable iff (!rs_n_q)
    base_force_on |-> mode == SUB_CONSTLAT); // R8
endmodule

// File: tb/sim_pwr_mode_ctrl.sv
module sim_pwr_mode_ctrl;
  localparam int NS   = 4;
  localparam int WRC  = 3;
  localparam int WDOG = 20000;

  logic clk = 1'b0;
  logic rst_n;
  logic off_req, task_const_lat, task_low_pwr;
  logic wake_pin, wake_analog, wake_field, wake_reset;
  logic dbg_active, cpu_idle, periph_busy;
  logic [NS-1:0] sect_on, ret_en, ram_pwr, ram_ret;
  logic sys_off, core_pwr_en, base_force_on, sys_reset_req, ev_sleep_enter, ev_sleep_exit;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  always #10 clk = ~clk;

  pwr_mode_ctrl #(.NUM_SECTIONS(NS), .WAKE_RST_CYCLES(WRC)) u0 (
    .clk(clk), .rst_n(rst_n), .off_req(off_req), .task_const_lat(task_const_lat),
    .task_low_pwr(task_low_pwr), .wake_pin(wake_pin), .wake_analog(wake_analog),
    .wake_field(wake_field), .wake_reset(wake_reset), .dbg_active(dbg_active),
    .cpu_idle(cpu_idle), .periph_busy(periph_busy), .sect_on(sect_on), .ret_en(ret_en),
    .sys_off(sys_off), .core_pwr_en(core_pwr_en), .base_force_on(base_force_on),
    .sys_reset_req(sys_reset_req), .ev_sleep_enter(ev_sleep_enter),
    .ev_sleep_exit(ev_sleep_exit), .ram_pwr(ram_pwr), .ram_ret(ram_ret)
  );

  // {task_const, task_low, cpu_idle, periph_busy, expected base_force_on}
  localparam logic [4:0] VEC [9] = '{
    5'b00100, 5'b10101, 5'b00110, 5'b00000, 5'b00101,
    5'b01100, 5'b11101, 5'b01000, 5'b00100
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pulse_off();
    off_req = 1'b1;
    @(negedge clk);
    off_req = 1'b0;
  endtask

  // wake vector bit order: {reset, field, analog, pin}
  task automatic do_wake(input logic [3:0] w, input string req);
    {wake_reset, wake_field, wake_analog, wake_pin} = w;
    @(negedge clk);
    {wake_reset, wake_field, wake_analog, wake_pin} = 4'b0000;
    for (int i = 0; i < WRC; i++) begin
      chk({req, " R4 reset pulse"}, {31'd0, sys_reset_req}, 32'd1);
      @(negedge clk);
    end
    chk("R4 reset pulse ends", {31'd0, sys_reset_req}, 32'd0);
    chk({req, " back active"}, {30'd0, sys_off, core_pwr_en}, 32'b01);
  endtask

  initial begin
    while (cyc < WDOG) begin
      @(posedge clk);
      cyc++;
    end
    n_fail++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    off_req = 0; task_const_lat = 0; task_low_pwr = 0;
    wake_pin = 0; wake_analog = 0; wake_field = 0; wake_reset = 0;
    dbg_active = 0; cpu_idle = 0; periph_busy = 0;
    sect_on = 4'b1010; ret_en = 4'b0110;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R6 reset state
    chk("R6 off/pwr/rst", {29'd0, sys_off, core_pwr_en, sys_reset_req}, 32'b010);
    chk("R6 no events", {30'd0, ev_sleep_enter, ev_sleep_exit}, 32'd0);
    cpu_idle = 1'b1;
    @(negedge clk);
    chk("R6 default low power", {31'd0, base_force_on}, 32'd0);
    @(negedge clk);

    // R7 / R8 vector walk
    for (int v = 0; v < 9; v++) begin
      {task_const_lat, task_low_pwr, cpu_idle, periph_busy} = VEC[v][4:1];
      @(negedge clk);
      chk($sformatf("R7 R8 vector %0d", v), {31'd0, base_force_on}, {31'd0, VEC[v][0]});
    end
    task_const_lat = 0; task_low_pwr = 0;
    @(negedge clk);

    // R9 events, cpu_idle currently 1
    cpu_idle = 1'b0;
    @(negedge clk);
    chk("R9 exit pulse", {30'd0, ev_sleep_exit, ev_sleep_enter}, 32'b10);
    @(negedge clk);
    chk("R9 exit one cycle", {31'd0, ev_sleep_exit}, 32'd0);
    cpu_idle = 1'b1;
    @(negedge clk);
    chk("R9 enter pulse", {30'd0, ev_sleep_enter, ev_sleep_exit}, 32'b10);
    @(negedge clk);
    chk("R9 enter one cycle", {31'd0, ev_sleep_enter}, 32'd0);

    // R10 active RAM
    chk("R10 active ram_pwr", {28'd0, ram_pwr}, 32'b1010);
    chk("R10 active ram_ret", {28'd0, ram_ret}, 32'b1110);

    // R3 wake input outside off has no effect
    wake_pin = 1'b1;
    @(negedge clk);
    wake_pin = 1'b0;
    chk("R3 wake ignored when active", {30'd0, sys_reset_req, sys_off}, 32'd0);

    // select constant latency before going off
    task_const_lat = 1'b1;
    @(negedge clk);
    task_const_lat = 1'b0;
    chk("R8 const idle", {31'd0, base_force_on}, 32'd1);

    // R1 direct off
    pulse_off();
    chk("R1 off entered", {30'd0, sys_off, core_pwr_en}, 32'b10);
    chk("R10 off ram_pwr", {28'd0, ram_pwr}, 32'd0);
    chk("R10 off ram_ret", {28'd0, ram_ret}, 32'b0110);
    chk("R8 no force when off", {31'd0, base_force_on}, 32'd0);
    repeat (4) @(negedge clk);
    chk("R3 stays off", {31'd0, sys_off}, 32'd1);
    cpu_idle = 1'b0;
    @(negedge clk);
    chk("R9 no exit event when off", {31'd0, ev_sleep_exit}, 32'd0);
    cpu_idle = 1'b1;
    pulse_off();
    chk("R3 off request while off", {30'd0, sys_off, sys_reset_req}, 32'b10);
    do_wake(4'b0001, "R3 pin");
    chk("R4 low power after wake", {31'd0, base_force_on}, 32'd0);

    // R2 pending off
    periph_busy = 1'b1;
    pulse_off();
    chk("R2 held while busy", {31'd0, sys_off}, 32'd0);
    repeat (3) @(negedge clk);
    chk("R2 still held", {31'd0, sys_off}, 32'd0);
    periph_busy = 1'b0;
    @(negedge clk);
    chk("R2 off after busy clears", {31'd0, sys_off}, 32'd1);
    do_wake(4'b0010, "R3 analog");

    pulse_off();
    chk("R1 off again", {31'd0, sys_off}, 32'd1);
    do_wake(4'b0100, "R3 field");
    pulse_off();
    do_wake(4'b1000, "R3 ext reset");

    // R5 emulated off
    dbg_active = 1'b1;
    pulse_off();
    dbg_active = 1'b0;
    chk("R5 emulated off flag", {31'd0, sys_off}, 32'd1);
    chk("R5 core stays powered", {31'd0, core_pwr_en}, 32'd1);
    chk("R5 ram kept", {28'd0, ram_pwr}, 32'b1010);
    @(negedge clk);
    chk("R5 latched on entry", {31'd0, core_pwr_en}, 32'd1);
    do_wake(4'b0001, "R5 emul wake");

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule